// File: doc/BRIEF.md
# Strap-Sampled Configuration and Backed-Up Control Registers

This block holds two byte-wide configuration registers that sit in different reset domains of a bridge device. At the rising edge of a power-good input it samples two board straps. The first is a safe-mode strap. When it is set, the processor frequency multiplier is pinned to all ones and firmware address swapping is armed. The second is a no-reboot strap, which disables the watchdog's system reboot.

Software reaches both registers through a small byte port. The port has a write strobe, write data and combinational read data. Two rules filter software writes. The multiplier field cannot be written while safe mode is set. The no-reboot bit cannot be cleared while its strap was sampled high. Each bit is reset only by the reset of its own domain:

- The core reset covers the strap capture and the status bits.
- The RTC-well reset covers firmware swap and the multiplier.
- The resume-well reset covers the processor self-test enable.

The block drives four outputs:

- the effective multiplier;
- the reboot-disable level;
- an INIT request, issued while the processor is held in reset and self-test is enabled;
- address bit 16, inverted for firmware code-space cycles when swap is on.

Top module: `strap_ctrl_regs`

## Requirements
- R1: After reset, with safe mode clear, the control register (address 8'hD5) reads 8'h0F and the status register (address 8'hD4) reads 8'h00.
- R2: A power-good rise is a clock edge at which pwrok_i is 1 and was 0 at the previous edge. At that edge, status bit 2 (safe mode) takes strap_safe_i. Software writes never change this bit.
- R3: While safe mode is 1, freq_mult_o and control bits 3:0 read 4'hF, and writes to the field are ignored. The stored value is left unchanged, so it is still there after safe mode clears.
- R4: Status bit 1 drives no_reboot_o. It is set at a power-good rise that samples strap_noreboot_i high, and it is set by a write of 1. A write of 0 clears it only when the sampled strap was low.
- R5: A power-good rise that samples strap_safe_i high sets the swap bit and loads the multiplier with 4'hF, so the control register reads 8'h2F.
- R6: Control bit 5 (swap) is cleared only by rtc_rst_ni or by a write. addr16_o equals addr16_i inverted when swap is 1 and fw_code_cycle_i is 1; otherwise addr16_o equals addr16_i.
- R7: Control bit 4 (self-test enable) is cleared only by rsm_rst_ni or by a write. While it is 1, init_o is 1 whenever cpu_rst_i is 1 and stays 1 for one clock after cpu_rst_i falls. Otherwise init_o is 0.
- R8: Status reads {5'b0, safe, no_reboot, 1'b0} and control reads {2'b0, swap, self-test, multiplier}. Any other address reads 8'h00, and writes to reserved bits have no effect.
- R9: rst_ni clears safe mode, no-reboot and the sampled strap, but leaves all control bits unchanged. rsm_rst_ni leaves swap and the multiplier unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Core-domain reset, active low, asynchronous |
| rtc_rst_ni | input | 1 | RTC-well reset, active low, asynchronous |
| rsm_rst_ni | input | 1 | Resume-well reset, active low, asynchronous |
| pwrok_i | input | 1 | Power-good level |
| strap_safe_i | input | 1 | Safe-mode strap level |
| strap_noreboot_i | input | 1 | No-reboot strap level |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| freq_mult_o | output | 4 | Effective frequency multiplier |
| no_reboot_o | output | 1 | Watchdog reboot disable |
| cpu_rst_i | input | 1 | Processor reset active |
| init_o | output | 1 | INIT request, active high |
| fw_code_cycle_i | input | 1 | Current cycle targets firmware code space |
| addr16_i | input | 1 | Address bit 16 in |
| addr16_o | output | 1 | Address bit 16 out |

## Verification
Register writes and power-good captures take effect at the first clock edge that samples them. Their results therefore appear on reg_rdata_o, freq_mult_o and no_reboot_o from that edge on. Read data, addr16_o and the assertion of init_o follow their inputs within the same cycle. The release of init_o lags the fall of cpu_rst_i by exactly one edge, while asynchronous resets act at once. The bench drives inputs one nanosecond after the rising edge. It compares a behavioural model against every output at the falling edge, so each result is sampled in the cycle it becomes due.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W   = 8;
  localparam int FREQ_W  = 4;
  localparam int BIT_NR  = 1;
  localparam int BIT_SAFE = 2;
  localparam int BIT_BIST = 4;
  localparam int BIT_TOP = 5;
  localparam logic [FREQ_W-1:0] FREQ_SAFE = '1;
endpackage

// File: rtl/scr_strap_capture.sv
module scr_strap_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrok_i,
  input  logic strap_safe_i,
  input  logic strap_nr_i,
  input  logic sts_we_i,
  input  logic nr_wbit_i,
  output logic rise_o,
  output logic safe_o,
  output logic nr_o,
  output logic nr_strap_o
);
  logic pwrok_q, safe_q, nr_q, nr_strap_q;

  assign rise_o = pwrok_i & ~pwrok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwrok_q    <= 1'b0;
      safe_q     <= 1'b0;
      nr_q       <= 1'b0;
      nr_strap_q <= 1'b0;
    end else begin
      pwrok_q <= pwrok_i;
      if (rise_o) begin
        safe_q     <= strap_safe_i;
        nr_strap_q <= strap_nr_i;
        if (strap_nr_i) nr_q <= 1'b1;
      end else if (sts_we_i) begin
        if (nr_wbit_i)        nr_q <= 1'b1;
        else if (!nr_strap_q) nr_q <= 1'b0;  // strap locks the bit set
      end
    end
  end

  assign safe_o     = safe_q;
  assign nr_o       = nr_q;
  assign nr_strap_o = nr_strap_q;
endmodule

// File: rtl/scr_backup_ctrl.sv
module scr_backup_ctrl
  import scr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rtc_rst_ni,
  input  logic              rsm_rst_ni,
  input  logic              rise_i,
  input  logic              strap_safe_i,
  input  logic              safe_i,
  input  logic              ctl_we_i,
  input  logic              top_wbit_i,
  input  logic              bist_wbit_i,
  input  logic [FREQ_W-1:0] freq_wdata_i,
  output logic              top_o,
  output logic              bist_o,
  output logic [FREQ_W-1:0] freq_o
);
  logic              top_q, bist_q;
  logic [FREQ_W-1:0] freq_q;
  logic              safe_load;

  assign safe_load = rise_i & strap_safe_i;

  // RTC well: swap and multiplier
  always_ff @(posedge clk_i or negedge rtc_rst_ni) begin
    if (!rtc_rst_ni) begin
      top_q  <= 1'b0;
      freq_q <= FREQ_SAFE;
    end else if (safe_load) begin
      top_q  <= 1'b1;
      freq_q <= FREQ_SAFE;
    end else if (ctl_we_i) begin
      top_q <= top_wbit_i;
      if (!safe_i) freq_q <= freq_wdata_i;
    end
  end

  // resume well: self-test enable
  always_ff @(posedge clk_i or negedge rsm_rst_ni) begin
    if (!rsm_rst_ni)   bist_q <= 1'b0;
    else if (ctl_we_i) bist_q <= bist_wbit_i;
  end

  assign top_o  = top_q;
  assign bist_o = bist_q;
  assign freq_o = safe_i ? FREQ_SAFE : freq_q;
endmodule

// File: rtl/scr_cpu_if.sv
module scr_cpu_if #(
  parameter int INIT_HOLD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bist_i,
  input  logic cpu_rst_i,
  input  logic top_i,
  input  logic fw_code_i,
  input  logic addr16_i,
  output logic init_o,
  output logic addr16_o
);
  logic hold_act;

  generate
    if (INIT_HOLD == 0) begin : g_nohold
      assign hold_act = 1'b0;
    end else begin : g_hold
      localparam int CW = $clog2(INIT_HOLD + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (cpu_rst_i)      cnt_q <= CW'(INIT_HOLD);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign hold_act = (cnt_q != '0);
    end
  endgenerate

  assign init_o   = bist_i & (cpu_rst_i | hold_act);
  assign addr16_o = addr16_i ^ (top_i & fw_code_i);
endmodule

// File: rtl/strap_ctrl_regs.sv
module strap_ctrl_regs
  import scr_pkg::*;
#(
  parameter logic [7:0] STS_ADDR  = 8'hD4,
  parameter logic [7:0] CTL_ADDR  = 8'hD5,
  parameter int         INIT_HOLD = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_rst_ni,
  input  logic              rsm_rst_ni,
  input  logic              pwrok_i,
  input  logic              strap_safe_i,
  input  logic              strap_noreboot_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [FREQ_W-1:0] freq_mult_o,
  output logic              no_reboot_o,
  input  logic              cpu_rst_i,
  output logic              init_o,
  input  logic              fw_code_cycle_i,
  input  logic              addr16_i,
  output logic              addr16_o
);
  logic sts_hit, ctl_hit, sts_we, ctl_we;
  logic rise, safe_q, nr_q, nr_strap_q;
  logic top_q, bist_q;
  logic [FREQ_W-1:0] freq_eff;

  assign sts_hit = (reg_addr_i == STS_ADDR);
  assign ctl_hit = (reg_addr_i == CTL_ADDR);
  assign sts_we  = reg_we_i & sts_hit;
  assign ctl_we  = reg_we_i & ctl_hit;

  scr_strap_capture u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwrok_i     (pwrok_i),
    .strap_safe_i(strap_safe_i),
    .strap_nr_i  (strap_noreboot_i),
    .sts_we_i    (sts_we),
    .nr_wbit_i   (reg_wdata_i[BIT_NR]),
    .rise_o      (rise),
    .safe_o      (safe_q),
    .nr_o        (nr_q),
    .nr_strap_o  (nr_strap_q)
  );

  scr_backup_ctrl u_bkp (
    .clk_i       (clk_i),
    .rtc_rst_ni  (rtc_rst_ni),
    .rsm_rst_ni  (rsm_rst_ni),
    .rise_i      (rise),
    .strap_safe_i(strap_safe_i),
    .safe_i      (safe_q),
    .ctl_we_i    (ctl_we),
    .top_wbit_i  (reg_wdata_i[BIT_TOP]),
    .bist_wbit_i (reg_wdata_i[BIT_BIST]),
    .freq_wdata_i(reg_wdata_i[FREQ_W-1:0]),
    .top_o       (top_q),
    .bist_o      (bist_q),
    .freq_o      (freq_eff)
  );

  scr_cpu_if #(.INIT_HOLD(INIT_HOLD)) u_cpu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bist_i   (bist_q),
    .cpu_rst_i(cpu_rst_i),
    .top_i    (top_q),
    .fw_code_i(fw_code_cycle_i),
    .addr16_i (addr16_i),
    .init_o   (init_o),
    .addr16_o (addr16_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sts_hit) begin
      reg_rdata_o[BIT_SAFE] = safe_q;
      reg_rdata_o[BIT_NR]   = nr_q;
    end else if (ctl_hit) begin
      reg_rdata_o[BIT_TOP]      = top_q;
      reg_rdata_o[BIT_BIST]     = bist_q;
      reg_rdata_o[FREQ_W-1:0]   = freq_eff;
    end
  end

  assign freq_mult_o = freq_eff;
  assign no_reboot_o = nr_q;
endmodule

// File: rtl/scr_checker.sv
module scr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rtc_rst_ni,
  input logic       rsm_rst_ni,
  input logic       rise,
  input logic       strap_safe_i,
  input logic       safe_q,
  input logic       nr_strap_q,
  input logic       no_reboot_o,
  input logic [3:0] freq_mult_o,
  input logic       ctl_we,
  input logic       top_q,
  input logic       bist_q,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_rdata_o,
  input logic       cpu_rst_i,
  input logic       init_o,
  input logic       fw_code_cycle_i,
  input logic       addr16_i,
  input logic       addr16_o
);
  AST_SAFE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> safe_q == $past(strap_safe_i)); // R2

  AST_SAFE_PINS_FREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_q |-> freq_mult_o == 4'hF); // R3

  AST_NR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nr_strap_q |-> no_reboot_o); // R4

  AST_TOP_FALL_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rtc_rst_ni)
    $fell(top_q) |-> $past(ctl_we)); // R6

  AST_A16_FEATURE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fw_code_cycle_i |-> addr16_o == addr16_i); // R6

  AST_INIT_ON_CPURST: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    (cpu_rst_i && bist_q) |-> init_o); // R7

  AST_CTL_WRITE_BITS: assert property (@(posedge clk_i)
    disable iff (!rtc_rst_ni || !rsm_rst_ni)
    (ctl_we && !(rise && strap_safe_i)) |=>
      ({2'b00, top_q, bist_q, 4'h0} == ($past(reg_wdata_i) & 8'h30))); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != 8'hD4 && reg_addr_i != 8'hD5) |-> reg_rdata_o == 8'h00); // R8
endmodule

bind strap_ctrl_regs scr_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rtc_rst_ni     (rtc_rst_ni),
  .rsm_rst_ni     (rsm_rst_ni),
  .rise           (rise),
  .strap_safe_i   (strap_safe_i),
  .safe_q         (safe_q),
  .nr_strap_q     (nr_strap_q),
  .no_reboot_o    (no_reboot_o),
  .freq_mult_o    (freq_mult_o),
  .ctl_we         (ctl_we),
  .top_q          (top_q),
  .bist_q         (bist_q),
  .reg_wdata_i    (reg_wdata_i),
  .reg_addr_i     (reg_addr_i),
  .reg_rdata_o    (reg_rdata_o),
  .cpu_rst_i      (cpu_rst_i),
  .init_o         (init_o),
  .fw_code_cycle_i(fw_code_cycle_i),
  .addr16_i       (addr16_i),
  .addr16_o       (addr16_o)
);

// File: tb/strap_ctrl_regs_test.sv
`timescale 1ns/1ps
module strap_ctrl_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, rtc_n = 1'b0, rsm_n = 1'b0;
  logic pwrok = 1'b0, s_safe = 1'b0, s_nr = 1'b0;
  logic [7:0] addr = 8'h00, wd = 8'h00;
  logic we = 1'b0, cpu_rst = 1'b0, fwc = 1'b0, a16 = 1'b0;
  logic [7:0] rdata;
  logic [3:0] fmul;
  logic nr_o, init, a16_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;

  // model state
  int m_pq = 0, m_safe = 0, m_nrs = 0, m_nr = 0, m_cnt = 0;
  int m_top = 0, m_bist = 0, m_freq = 15;

  always #2 clk = ~clk;

  strap_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .rtc_rst_ni(rtc_n), .rsm_rst_ni(rsm_n),
    .pwrok_i(pwrok), .strap_safe_i(s_safe), .strap_noreboot_i(s_nr),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .freq_mult_o(fmul), .no_reboot_o(nr_o), .cpu_rst_i(cpu_rst), .init_o(init),
    .fw_code_cycle_i(fwc), .addr16_i(a16), .addr16_o(a16_o)
  );

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_async();
    if (!rst_n) begin m_pq = 0; m_safe = 0; m_nrs = 0; m_nr = 0; m_cnt = 0; end
    if (!rtc_n) begin m_top = 0; m_freq = 15; end
    if (!rsm_n) m_bist = 0;
  endtask

  always @(posedge clk) begin
    int rise, pq, sf, nrs, nr, cnt, top, bist, fr;
    model_async();
    rise = (pwrok && m_pq == 0) ? 1 : 0;
    pq = m_pq; sf = m_safe; nrs = m_nrs; nr = m_nr; cnt = m_cnt;
    top = m_top; bist = m_bist; fr = m_freq;
    if (rst_n) begin
      pq = pwrok;
      if (rise != 0) begin
        sf = s_safe; nrs = s_nr;
        if (s_nr) nr = 1;
      end else if (we && addr == 8'hD4) begin
        if (wd[1]) nr = 1;
        else if (m_nrs == 0) nr = 0;
      end
      cnt = cpu_rst ? 1 : (m_cnt > 0 ? m_cnt - 1 : 0);
    end
    if (rtc_n) begin
      if (rise != 0 && s_safe) begin top = 1; fr = 15; end
      else if (we && addr == 8'hD5) begin
        top = wd[5];
        if (m_safe == 0) fr = int'(wd[3:0]);
      end
    end
    if (rsm_n && we && addr == 8'hD5) bist = wd[4];
    m_pq = pq; m_safe = sf; m_nrs = nrs; m_nr = nr; m_cnt = cnt;
    m_top = top; m_bist = bist; m_freq = fr;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int ef, er;
      model_async();
      ef = (m_safe != 0) ? 15 : m_freq;
      if (addr == 8'hD4)      er = m_safe * 4 + m_nr * 2;
      else if (addr == 8'hD5) er = m_top * 32 + m_bist * 16 + ef;
      else                    er = 0;
      check("R8 rdata", int'(rdata), er);
      check("R3 freq_mult_o", int'(fmul), ef);
      check("R4 no_reboot_o", int'(nr_o), m_nr);
      check("R7 init_o", int'(init), (m_bist != 0 && (cpu_rst || m_cnt > 0)) ? 1 : 0);
      check("R6 addr16_o", int'(a16_o), int'(a16 ^ (m_top != 0 && fwc)));
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    tick(); addr = a; wd = d; we = 1'b1;
    tick(); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    tick(); addr = a; we = 1'b0;
    @(negedge clk); check(tag, int'(rdata), int'(exp));
  endtask

  task automatic pwr(logic ss, logic sn);
    tick(); pwrok = 1'b0;
    tick(); pwrok = 1'b1; s_safe = ss; s_nr = sn;
    tick();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1; rtc_n = 1'b1; rsm_n = 1'b1;
    cmp_on = 1;
    rd(8'hD5, 8'h0F, "R1 ctl reset");
    rd(8'hD4, 8'h00, "R1 sts reset");

    // safe strap captured
    pwr(1'b1, 1'b0);
    rd(8'hD4, 8'h04, "R2 safe captured");
    rd(8'hD5, 8'h2F, "R5 safe strap ctl");
    wr(8'hD4, 8'h00);
    rd(8'hD4, 8'h04, "R2 safe read-only");
    wr(8'hD5, 8'h07);
    rd(8'hD5, 8'h0F, "R3 freq write ignored");
    check("R3 freq_mult_o pinned", int'(fmul), 15);
    pwr(1'b0, 1'b0);
    rd(8'hD5, 8'h0F, "R3 stored value kept");
    wr(8'hD5, 8'h15);
    rd(8'hD5, 8'h15, "R3 freq writable");

    // no-reboot strap lock
    pwr(1'b0, 1'b1);
    rd(8'hD4, 8'h02, "R4 strap sets no_reboot");
    wr(8'hD4, 8'h00);
    rd(8'hD4, 8'h02, "R4 clear blocked");
    wr(8'hD4, 8'hFD);
    rd(8'hD4, 8'h02, "R8 reserved status writes");
    s_nr = 1'b0;
    tick(); rst_n = 1'b0;
    @(negedge clk); addr = 8'hD4;
    @(negedge clk); check("R9 core reset clears status", int'(rdata), 0);
    tick(); rst_n = 1'b1; tick(); tick();
    rd(8'hD5, 8'h15, "R9 ctl survives core reset");
    wr(8'hD4, 8'h02);
    rd(8'hD4, 8'h02, "R4 software set");
    wr(8'hD4, 8'h00);
    rd(8'hD4, 8'h00, "R4 software clear");

    // swap and address bit 16
    wr(8'hD5, 8'h35);
    rd(8'hD5, 8'h35, "R6 swap set");
    tick(); fwc = 1'b1; a16 = 1'b0;
    @(negedge clk); check("R6 code space inverted", int'(a16_o), 1);
    tick(); fwc = 1'b0; a16 = 1'b1;
    @(negedge clk); check("R6 feature space passes", int'(a16_o), 1);
    tick(); rst_n = 1'b0; rsm_n = 1'b0;
    tick(); rst_n = 1'b1; rsm_n = 1'b1; tick(); tick();
    rd(8'hD5, 8'h25, "R9 swap and freq survive resume reset");
    tick(); rtc_n = 1'b0;
    tick(); rtc_n = 1'b1;
    rd(8'hD5, 8'h0F, "R6 rtc reset clears swap");

    // self-test INIT
    wr(8'hD5, 8'h10);
    tick(); cpu_rst = 1'b1;
    @(negedge clk); check("R7 init with cpu reset", int'(init), 1);
    tick(); cpu_rst = 1'b0;
    @(negedge clk); check("R7 init hold", int'(init), 1);
    tick();
    @(negedge clk); check("R7 init released", int'(init), 0);
    wr(8'hD5, 8'h00);
    tick(); cpu_rst = 1'b1;
    @(negedge clk); check("R7 no init when disabled", int'(init), 0);
    tick(); cpu_rst = 1'b0;

    // unmapped addresses
    rd(8'h00, 8'h00, "R8 unmapped 00");
    wr(8'hD6, 8'hFF);
    rd(8'hD6, 8'h00, "R8 unmapped D6");
    rd(8'hD5, 8'h00, "R8 ctl untouched by D6");

    tick(); tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule